// File: doc/BRIEF.md
# SDRAM Bank Configuration Register Unit

This block holds the software-visible control words of a multi-bank SDRAM controller and turns them into a bank hit decision for any system address. Software reaches it through two bus registers on a simple synchronous register bus. The index register at bus address 0x10 selects an internal word. The data register at bus address 0x11 reads or writes that word. The unit stores two sticky error words, an error address, global configuration, a read-only status word, refresh, idle-timer, timing and ECC settings, an ECC error word and up to four bank words.

The global mapping switch is configuration bit 31. A three-state machine tracks it. `MAP_IDLE` is the reset state: mapping is off and no loss is recorded. The transition `GO_ON` is a configuration write with bit 31 set, taken from `MAP_IDLE` or `MAP_DOWN`, and it enters `MAP_ON`. The transition `GO_DOWN` is a configuration write with bit 31 clear, taken from `MAP_ON`, and it enters `MAP_DOWN`. In `MAP_DOWN` mapping is off and status bit 31 reads as 1. Any other write leaves the state where it is. Each bank word carries an enable, a base address and an encoded size. A combinational decoder compares a probe address against every bank and reports a single hit flag together with the lowest-numbered bank that matches. An interrupt line stays high while the ECC error word is nonzero.

Top module: `sdbank_ctl`

## Requirements
- R1: A write to bus address 0x10 loads the 32-bit index, and a read of 0x10 returns it. Reads and writes at bus address 0x11 reach the internal word selected by the index. Every other bus address reads as 0, and writes to those addresses change nothing.
- R2: After reset, configuration (index 0x20) reads 0x00800000, refresh (0x30) reads 0x05F00000, idle timer (0x34) reads 0x07C00000 and timing (0x80) reads 0x00854009. All other words read 0, the interrupt is low and there is no hit.
- R3: The error words at index 0x00 and 0x08 are cleared by writing 1s: each 1 bit written clears the stored bit in the same position. Bits on err_set0 and err_set1 are OR-ed into these words every cycle. A set bit wins over a clear of the same bit in the same cycle.
- R4: A configuration write stores only bits 31:21. A write with bit 31 set, while mapping is off, takes `GO_ON` and clears status bit 31. A write with bit 31 clear, while mapping is on, takes `GO_DOWN` and sets status bit 31.
- R5: Status bit 30 is set when configuration bit 30 changes from 0 to 1 and cleared when it changes from 1 to 0. The status word at index 0x24 ignores bus writes.
- R6: Stored values follow fixed write masks. Refresh keeps value & 0x3FF80000. Idle timer keeps (value & 0xF8000000) | 0x07C00000. Timing keeps value & 0x018FC01F. ECC configuration (0x94) keeps value & 0x00F00000. The error address (0x10) keeps all 32 bits.
- R7: Bank words sit at index 0x40 + 4*n and are stored as value & 0xFFDEE001. Bit 0 is the bank enable, bits 31:23 are the base address and bits 19:17 are the size code. The bank covers [base, base + (4 MiB << code)). Code 7 never produces a hit.
- R8: A bank can hit only while its own enable bit and configuration bit 31 are both set.
- R9: The ECC error word (0x98) keeps value & 0xFFF0F000. ecc_irq is high exactly while this word is nonzero. It changes on the clock edge that writes the word.
- R10: Reading an index that names no word returns 0xFFFFFFFF.
- R11: When several banks cover the probe address, probe_hit is 1 and probe_bank gives the lowest-numbered of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Bus register number |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| err_set0 | input | 32 | Bits to set in error word 0 |
| err_set1 | input | 32 | Bits to set in error word 1 |
| probe_addr | input | 32 | System address to decode |
| probe_hit | output | 1 | Some enabled bank covers probe_addr |
| probe_bank | output | IDX_W | Lowest-numbered hitting bank |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
The bench builds the unit with its defaults: four banks and a 10-bit bus address. With four banks, every bank index from 0x40 to 0x4C can be reached, together with overlap cases where the lowest-index rule has to choose among up to four matching banks. Random bank words cover all eight size codes, including the invalid code 7, and random configuration writes drive the mapping machine through all three states. Directed cases check the upper boundary of the 4 MiB size, overlapping banks, and a set and a clear of the same error bit in the same cycle.

// File: rtl/sdbank_pkg.sv
package sdbank_pkg;
    localparam int WORD_W    = 32;
    localparam int MIN_SHIFT = 22;  // smallest bank is 4 MiB

    localparam logic [WORD_W-1:0] OFS_ERR0  = 32'h00;
    localparam logic [WORD_W-1:0] OFS_ERR1  = 32'h08;
    localparam logic [WORD_W-1:0] OFS_EADDR = 32'h10;
    localparam logic [WORD_W-1:0] OFS_CFG   = 32'h20;
    localparam logic [WORD_W-1:0] OFS_STAT  = 32'h24;
    localparam logic [WORD_W-1:0] OFS_RFR   = 32'h30;
    localparam logic [WORD_W-1:0] OFS_IDLE  = 32'h34;
    localparam logic [WORD_W-1:0] OFS_BANK0 = 32'h40;
    localparam logic [WORD_W-1:0] OFS_TIM   = 32'h80;
    localparam logic [WORD_W-1:0] OFS_ECCC  = 32'h94;
    localparam logic [WORD_W-1:0] OFS_ECCS  = 32'h98;

    localparam logic [WORD_W-1:0] MSK_RFR   = 32'h3FF8_0000;
    localparam logic [WORD_W-1:0] MSK_IDLE  = 32'hF800_0000;
    localparam logic [WORD_W-1:0] FIX_IDLE  = 32'h07C0_0000;
    localparam logic [WORD_W-1:0] MSK_TIM   = 32'h018F_C01F;
    localparam logic [WORD_W-1:0] MSK_ECCC  = 32'h00F0_0000;
    localparam logic [WORD_W-1:0] MSK_ECCS  = 32'hFFF0_F000;
    localparam logic [WORD_W-1:0] MSK_BANK  = 32'hFFDE_E001;

    localparam logic [WORD_W-1:0] RST_RFR   = 32'h05F0_0000;
    localparam logic [WORD_W-1:0] RST_IDLE  = 32'h07C0_0000;
    localparam logic [WORD_W-1:0] RST_TIM   = 32'h0085_4009;
    localparam logic [9:0]        RST_CFGLO = 10'b00_0000_0100; // cfg bits 30:21

    localparam logic [WORD_W-1:0] ALL_ONES  = '1;

    typedef enum logic [1:0] {
        MAP_IDLE = 2'd0,
        MAP_ON   = 2'd1,
        MAP_DOWN = 2'd2
    } map_state_e;
endpackage

// File: rtl/sdbank_map_fsm.sv
module sdbank_map_fsm
    import sdbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_wbit31,
    output logic map_on,
    output logic map_lost
);
    map_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MAP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MAP_IDLE: if (cfg_wr && cfg_wbit31)  state_d = MAP_ON;   // GO_ON
            MAP_ON:   if (cfg_wr && !cfg_wbit31) state_d = MAP_DOWN; // GO_DOWN
            MAP_DOWN: if (cfg_wr && cfg_wbit31)  state_d = MAP_ON;   // GO_ON
            default:  state_d = MAP_IDLE;
        endcase
    end

    always_comb begin
        map_on   = 1'b0;
        map_lost = 1'b0;
        unique case (state_q)
            MAP_IDLE: ;
            MAP_ON:   map_on = 1'b1;
            MAP_DOWN: map_lost = 1'b1;
            default:  ;
        endcase
    end

    p_go_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (map_on && cfg_wr && !cfg_wbit31) |=> (map_lost && !map_on));
    p_go_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wbit31) |=> (map_on && !map_lost));
endmodule

// File: rtl/sdbank_regs.sv
module sdbank_regs
    import sdbank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BUS_AW    = 10
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bus_en,
    input  logic                               bus_we,
    input  logic [BUS_AW-1:0]                  bus_addr,
    input  logic [WORD_W-1:0]                  bus_wdata,
    output logic [WORD_W-1:0]                  bus_rdata,
    input  logic [WORD_W-1:0]                  err_set0,
    input  logic [WORD_W-1:0]                  err_set1,
    input  logic                               map_on,
    input  logic                               map_lost,
    output logic                               cfg_wr,
    output logic                               cfg_wbit31,
    output logic [NUM_BANKS-1:0][WORD_W-1:0]   bank_words,
    output logic                               ecc_irq
);
    localparam logic [BUS_AW-1:0] BUS_IDX = BUS_AW'(10'h010);
    localparam logic [BUS_AW-1:0] BUS_DAT = BUS_AW'(10'h011);

    logic [WORD_W-1:0] ofs_q, err0_q, err1_q, eaddr_q, rfr_q, idle_q;
    logic [WORD_W-1:0] tim_q, eccc_q, eccs_q, ird, stat_word, cfg_word;
    logic [9:0]        cfg_lo_q;
    logic              stat30_q, irq_q;
    logic              wr_idx, wr_dat, rd_any;

    assign wr_idx = bus_en && bus_we && (bus_addr == BUS_IDX);
    assign wr_dat = bus_en && bus_we && (bus_addr == BUS_DAT);
    assign rd_any = bus_en && !bus_we;

    assign cfg_wr     = wr_dat && (ofs_q == OFS_CFG);
    assign cfg_wbit31 = bus_wdata[31];
    assign cfg_word   = {map_on, cfg_lo_q, 21'b0};
    assign stat_word  = {map_lost, stat30_q, 30'b0};
    assign ecc_irq    = irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q    <= '0;
            err0_q   <= '0;
            err1_q   <= '0;
            eaddr_q  <= '0;
            cfg_lo_q <= RST_CFGLO;
            stat30_q <= 1'b0;
            rfr_q    <= RST_RFR;
            idle_q   <= RST_IDLE;
            tim_q    <= RST_TIM;
            eccc_q   <= '0;
            eccs_q   <= '0;
            irq_q    <= 1'b0;
        end else begin
            if (wr_idx) ofs_q <= bus_wdata;
            err0_q <= (err0_q & ~((wr_dat && ofs_q == OFS_ERR0) ? bus_wdata : '0)) | err_set0;
            err1_q <= (err1_q & ~((wr_dat && ofs_q == OFS_ERR1) ? bus_wdata : '0)) | err_set1;
            if (wr_dat) begin
                case (ofs_q)
                    OFS_EADDR: eaddr_q <= bus_wdata;
                    OFS_CFG: begin
                        cfg_lo_q <= bus_wdata[30:21];
                        stat30_q <= bus_wdata[30]; // follows every 0->1 / 1->0 edge
                    end
                    OFS_RFR:  rfr_q  <= bus_wdata & MSK_RFR;
                    OFS_IDLE: idle_q <= (bus_wdata & MSK_IDLE) | FIX_IDLE;
                    OFS_TIM:  tim_q  <= bus_wdata & MSK_TIM;
                    OFS_ECCC: eccc_q <= bus_wdata & MSK_ECCC;
                    OFS_ECCS: begin
                        eccs_q <= bus_wdata & MSK_ECCS;
                        irq_q  <= (bus_wdata & MSK_ECCS) != '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [WORD_W-1:0] word_q;
        logic              sel;
        assign sel = wr_dat && (ofs_q == OFS_BANK0 + WORD_W'(4 * b));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   word_q <= '0;
            else if (sel) word_q <= bus_wdata & MSK_BANK;
        end
        assign bank_words[b] = word_q;
    end

    always_comb begin
        case (ofs_q)
            OFS_ERR0:  ird = err0_q;
            OFS_ERR1:  ird = err1_q;
            OFS_EADDR: ird = eaddr_q;
            OFS_CFG:   ird = cfg_word;
            OFS_STAT:  ird = stat_word;
            OFS_RFR:   ird = rfr_q;
            OFS_IDLE:  ird = idle_q;
            OFS_TIM:   ird = tim_q;
            OFS_ECCC:  ird = eccc_q;
            OFS_ECCS:  ird = eccs_q;
            default:   ird = ALL_ONES;
        endcase
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (ofs_q == OFS_BANK0 + WORD_W'(4 * b)) ird = bank_words[b];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_any && bus_addr == BUS_IDX)      bus_rdata = ofs_q;
        else if (rd_any && bus_addr == BUS_DAT) bus_rdata = ird;
    end

    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && ofs_q == OFS_ERR0 && err_set0 == '0) |=> ((err0_q & $past(bus_wdata)) == '0));
    p_stat_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && ofs_q == OFS_STAT) |=> $stable(stat_word));
    p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ecc_irq) |-> $past(wr_dat && ofs_q == OFS_ECCS));
    p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && ofs_q == OFS_ECCS && (bus_wdata & MSK_ECCS) == '0) |=> !ecc_irq);
endmodule

// File: rtl/sdbank_match.sv
module sdbank_match
    import sdbank_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] addr,
    input  logic              map_on,
    output logic              hit
);
    logic [2:0]        code;
    logic [WORD_W:0]   diff;
    logic [WORD_W-1:0] beyond;
    logic              size_ok;

    assign code    = word[19:17];
    assign size_ok = (code != 3'd7);
    assign diff    = {1'b0, addr} - {1'b0, word[31:23], 23'b0};
    assign beyond  = diff[WORD_W-1:0] >> (6'(MIN_SHIFT) + 6'(code));
    assign hit     = map_on && word[0] && size_ok && !diff[WORD_W] && (beyond == '0);
endmodule

// File: rtl/sdbank_pick.sv
module sdbank_pick #(
    parameter int NUM_BANKS = 4,
    parameter int IDX_W     = 2
) (
    input  logic [NUM_BANKS-1:0] hit_vec,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/sdbank_ctl.sv
module sdbank_ctl
    import sdbank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BUS_AW    = 10,
    localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       err_set0,
    input  logic [31:0]       err_set1,
    input  logic [31:0]       probe_addr,
    output logic              probe_hit,
    output logic [IDX_W-1:0]  probe_bank,
    output logic              ecc_irq
);
    logic                             map_on, map_lost, cfg_wr, cfg_wbit31;
    logic [NUM_BANKS-1:0][WORD_W-1:0] bank_words;
    logic [NUM_BANKS-1:0]             hit_vec, below_sel;

    sdbank_map_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wbit31(cfg_wbit31),
        .map_on(map_on), .map_lost(map_lost)
    );

    sdbank_regs #(.NUM_BANKS(NUM_BANKS), .BUS_AW(BUS_AW)) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_set0(err_set0), .err_set1(err_set1), .map_on(map_on),
        .map_lost(map_lost), .cfg_wr(cfg_wr), .cfg_wbit31(cfg_wbit31),
        .bank_words(bank_words), .ecc_irq(ecc_irq)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
        sdbank_match i_match (
            .word(bank_words[b]), .addr(probe_addr), .map_on(map_on), .hit(hit_vec[b])
        );
        p_code7_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_words[b][19:17] == 3'd7) |-> !hit_vec[b]);
    end

    sdbank_pick #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) i_pick (
        .hit_vec(hit_vec), .any(probe_hit), .idx(probe_bank)
    );

    assign below_sel = (NUM_BANKS'(1) << probe_bank) - NUM_BANKS'(1);

    p_hit_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        probe_hit |-> map_on);
    p_lowest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        probe_hit |-> (hit_vec[probe_bank] && ((hit_vec & below_sel) == '0)));
endmodule

// File: tb/test_sdbank_ctl.sv
module test_sdbank_ctl;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, err_set0 = '0, err_set1 = '0, probe_addr = '0;
    logic        probe_hit, ecc_irq;
    logic [1:0]  probe_bank;
    int total = 0, bad = 0;
    bit done = 0;

    // bench model
    logic [31:0] m_err0, m_err1, m_ear, m_cfg, m_stat, m_rfr, m_idle, m_tim, m_eccc, m_eccs;
    logic [31:0] m_bank[4];

    sdbank_ctl i_sdbank_ctl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_set0(err_set0), .err_set1(err_set1),
        .probe_addr(probe_addr), .probe_hit(probe_hit), .probe_bank(probe_bank), .ecc_irq(ecc_irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_en = 0; bus_we = 0;
    endtask

    task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
        #2 d = bus_rdata; bus_en = 0;
    endtask

    task automatic ireg_wr(input logic [31:0] o, input logic [31:0] d);
        bus_wr(10'h010, o); bus_wr(10'h011, d); m_write(o, d);
    endtask

    task automatic ireg_rd(input logic [31:0] o, output logic [31:0] d);
        bus_wr(10'h010, o); bus_rd(10'h011, d);
    endtask

    function automatic void m_reset();
        m_err0 = 0; m_err1 = 0; m_ear = 0; m_cfg = 32'h0080_0000; m_stat = 0;
        m_rfr = 32'h05F0_0000; m_idle = 32'h07C0_0000; m_tim = 32'h0085_4009;
        m_eccc = 0; m_eccs = 0;
        for (int i = 0; i < 4; i++) m_bank[i] = 0;
    endfunction

    function automatic void m_write(input logic [31:0] o, input logic [31:0] d);
        logic [31:0] n;
        case (o)
            32'h00: m_err0 &= ~d;
            32'h08: m_err1 &= ~d;
            32'h10: m_ear = d;
            32'h20: begin
                n = d & 32'hFFE0_0000;
                if (!m_cfg[31] && n[31]) m_stat[31] = 0;
                else if (m_cfg[31] && !n[31]) m_stat[31] = 1;
                if (!m_cfg[30] && n[30]) m_stat[30] = 1;
                else if (m_cfg[30] && !n[30]) m_stat[30] = 0;
                m_cfg = n;
            end
            32'h30: m_rfr = d & 32'h3FF8_0000;
            32'h34: m_idle = (d & 32'hF800_0000) | 32'h07C0_0000;
            32'h40, 32'h44, 32'h48, 32'h4C: m_bank[(o - 32'h40) >> 2] = d & 32'hFFDE_E001;
            32'h80: m_tim = d & 32'h018F_C01F;
            32'h94: m_eccc = d & 32'h00F0_0000;
            32'h98: m_eccs = d & 32'hFFF0_F000;
            default: ;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [31:0] o);
        case (o)
            32'h00: return m_err0;
            32'h08: return m_err1;
            32'h10: return m_ear;
            32'h20: return m_cfg;
            32'h24: return m_stat;
            32'h30: return m_rfr;
            32'h34: return m_idle;
            32'h40, 32'h44, 32'h48, 32'h4C: return m_bank[(o - 32'h40) >> 2];
            32'h80: return m_tim;
            32'h94: return m_eccc;
            32'h98: return m_eccs;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic int m_hit(input logic [31:0] a);
        for (int i = 0; i < 4; i++) begin
            logic [31:0] w = m_bank[i];
            if (m_cfg[31] && w[0] && w[19:17] != 3'd7) begin
                longint base = longint'(w & 32'hFF80_0000);
                longint sz = longint'(4194304) << w[19:17];
                if (longint'(a) >= base && longint'(a) < base + sz) return i;
            end
        end
        return -1;
    endfunction

    task automatic probe(input string tag, input logic [31:0] a);
        int e;
        @(negedge clk); probe_addr = a; #2;
        e = m_hit(a);
        chk(tag, {31'b0, probe_hit}, {31'b0, e >= 0});
        if (e >= 0) chk(tag, {30'b0, probe_bank}, 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] offs[15] = '{32'h00, 32'h08, 32'h10, 32'h20, 32'h24, 32'h30, 32'h34,
                                  32'h40, 32'h44, 32'h48, 32'h4C, 32'h80, 32'h94, 32'h98, 32'h20};
        void'($urandom(32'd4711));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R2 reset values
        ireg_rd(32'h20, d); chk("R2 cfg", d, 32'h0080_0000);
        ireg_rd(32'h30, d); chk("R2 refresh", d, 32'h05F0_0000);
        ireg_rd(32'h34, d); chk("R2 idle", d, 32'h07C0_0000);
        ireg_rd(32'h80, d); chk("R2 timing", d, 32'h0085_4009);
        ireg_rd(32'h24, d); chk("R2 status", d, 32'h0);
        ireg_rd(32'h44, d); chk("R2 bank1", d, 32'h0);
        chk("R2 irq", {31'b0, ecc_irq}, 32'h0);
        probe("R2 nohit", 32'h0);

        // R1 index readback and foreign bus addresses
        bus_wr(10'h010, 32'h0000_0030);
        bus_wr(10'h012, 32'hDEAD_BEEF);
        bus_rd(10'h010, d); chk("R1 index", d, 32'h0000_0030);
        bus_rd(10'h012, d); chk("R1 other", d, 32'h0);

        // R10 unknown index
        ireg_rd(32'h0000_0120, d); chk("R10 unknown", d, 32'hFFFF_FFFF);
        ireg_rd(32'h0000_004C + 32'h100, d); chk("R10 alias", d, 32'hFFFF_FFFF);

        // R3 set, clear, set-wins
        @(negedge clk); err_set0 = 32'h0000_F0F0; err_set1 = 32'h0000_0003;
        @(negedge clk); err_set0 = 0; err_set1 = 0;
        m_err0 = 32'h0000_F0F0; m_err1 = 32'h3;
        ireg_wr(32'h00, 32'h0000_00F1);
        ireg_rd(32'h00, d); chk("R3 w1c err0", d, 32'h0000_F000);
        ireg_wr(32'h08, 32'h0000_0002);
        ireg_rd(32'h08, d); chk("R3 w1c err1", d, 32'h0000_0001);
        bus_wr(10'h010, 32'h00);
        @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = 10'h011; bus_wdata = 32'h0000_1000;
        err_set0 = 32'h0000_1000;
        @(negedge clk); bus_en = 0; bus_we = 0; err_set0 = 0;
        ireg_rd(32'h00, d); chk("R3 set wins", d, 32'h0000_F000);

        // R4/R5 status sequencing
        ireg_wr(32'h24, 32'hFFFF_FFFF);
        ireg_rd(32'h24, d); chk("R5 status ro", d, 32'h0);
        ireg_wr(32'h20, 32'h8000_0000);
        ireg_rd(32'h24, d); chk("R4 enable", d, 32'h0);
        ireg_wr(32'h20, 32'h001F_FFFF);
        ireg_rd(32'h24, d); chk("R4 disable", d, 32'h8000_0000);
        ireg_rd(32'h20, d); chk("R4 cfg mask", d, 32'h0);
        ireg_wr(32'h20, 32'h4000_0000);
        ireg_rd(32'h24, d); chk("R5 bit30 rise", d, 32'hC000_0000);
        ireg_wr(32'h20, 32'hC000_0000);
        ireg_rd(32'h24, d); chk("R5 enable keeps 30", d, 32'h4000_0000);
        ireg_wr(32'h20, 32'h8000_0000);
        ireg_rd(32'h24, d); chk("R5 bit30 fall", d, 32'h0);

        // R6 masks
        ireg_wr(32'h34, 32'h0000_0000);
        ireg_rd(32'h34, d); chk("R6 idle force", d, 32'h07C0_0000);
        ireg_wr(32'h30, 32'hFFFF_FFFF);
        ireg_rd(32'h30, d); chk("R6 refresh", d, 32'h3FF8_0000);

        // R7/R8/R11 directed decode
        ireg_wr(32'h40, 32'h0000_0001);             // bank0 base 0, 4 MiB
        ireg_wr(32'h44, 32'h0004_0001);             // bank1 base 0, 16 MiB
        ireg_wr(32'h48, 32'h010E_0001);             // bank2 code 7
        ireg_rd(32'h40, d); chk("R7 stored", d, 32'h0000_0001);
        probe("R11 overlap", 32'h0010_0000);
        chk("R11 lowest", {30'b0, probe_bank}, 32'h0);
        probe("R7 4MiB edge", 32'h0040_0000);
        chk("R7 edge bank", {30'b0, probe_bank}, 32'h1);
        probe("R7 16MiB end", 32'h0100_0000);
        chk("R7 code7 nohit", {31'b0, probe_hit}, 32'h0);
        ireg_wr(32'h20, 32'h0);
        probe("R8 global off", 32'h0010_0000);
        chk("R8 off", {31'b0, probe_hit}, 32'h0);
        ireg_wr(32'h20, 32'h8000_0000);
        ireg_wr(32'h40, 32'h0000_0000);
        probe("R8 bank off", 32'h0010_0000);
        chk("R8 bank0 skipped", {30'b0, probe_bank}, 32'h1);

        // R9 interrupt
        ireg_wr(32'h98, 32'h000F_0FFF);
        chk("R9 masked zero", {31'b0, ecc_irq}, 32'h0);
        ireg_wr(32'h98, 32'h0000_1000);
        chk("R9 rise", {31'b0, ecc_irq}, 32'h1);
        ireg_wr(32'h98, 32'h0);
        chk("R9 fall", {31'b0, ecc_irq}, 32'h0);

        // random mix checked against the model
        for (int n = 0; n < 400; n++) begin
            logic [31:0] o, v, a;
            int b;
            o = ($urandom % 8 == 0) ? (32'h1000 | ($urandom & 32'hFF)) : offs[$urandom % 15];
            v = $urandom;
            if (o >= 32'h40 && o <= 32'h4C) v = (v & 32'hF80E_0000) | ($urandom % 4 != 0);
            ireg_wr(o, v);
            ireg_rd(o, d);
            chk("R6 R7 R10 random readback", d, m_read(o));
            chk("R9 random irq", {31'b0, ecc_irq}, {31'b0, m_eccs != 0});
            b = $urandom % 4;
            a = (m_bank[b] & 32'hFF80_0000) + ($urandom % 32'h0200_0000);
            probe("R7 R8 R11 random probe", a);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule